// File: doc/BRIEF.md
# I2C Target Address Front End with Strap-Decoded Address

This block is the address-phase front end of an I2C target. It runs on a system clock that is much faster than the bus, oversamples SCL, SDA and one address-strap input, and works out which of four 7-bit addresses it answers to. It does this at every START by watching how the strap pin behaves. The pin may be tied low, tied high, wired to SDA or wired to SCL, and each of these produces a different pattern across the START edges.

Once the address is decoded, the block shifts in the first byte of the transfer. It compares the upper seven bits with the decoded address and, on a match, pulls SDA low for the acknowledge slot. It reports the decoded address, a one-cycle match pulse and the read/write bit. A STOP aborts the phase at any point. A repeated START aborts it as well, and also starts a new strap decode.

Top module: `i2c_strap_target`

## Requirements
- R1: After a synchronous active-low reset, the decoded address is 0x48, the SDA pull-down is off, the match pulse is low and the strap error flag is low.
- R2: The strap is sampled three times: while the bus is idle, at the START, and at the first SCL fall after the START. A strap held low in all three samples gives address 0x48.
- R3: A strap held high in all three samples gives address 0x49.
- R4: A strap that follows SDA (high while idle, low at START, low at the first SCL fall) gives address 0x4A.
- R5: A strap that follows SCL (high while idle, high at START, low at the first SCL fall) gives address 0x4B.
- R6: Any other strap pattern leaves the decoded address unchanged and sets the strap error flag. Only reset clears this flag.
- R7: Address bits are taken MSB first on SCL rising edges, and the eighth bit is R/W. After the eighth rise, `rw_o` holds that bit. `match_o` pulses for exactly one cycle if the first seven bits equal the decoded address.
- R8: On a match, the SDA pull-down turns on at the SCL fall after the eighth bit and turns off at the next SCL fall.
- R9: On a mismatch, the SDA pull-down stays off and the block ignores the bus until the next START.
- R10: A STOP (SDA rising while SCL is high) aborts the address phase and releases SDA. Bits clocked after a STOP without a new START produce no match and no acknowledge.
- R11: A repeated START aborts the current phase, decodes the strap again and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line (wired level), asynchronous |
| strap_i | input | 1 | Address-strap pin, asynchronous |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| addr_o | output | 7 | Currently decoded target address |
| match_o | output | 1 | One-cycle pulse when the address byte matches |
| rw_o | output | 1 | R/W bit of the last completed address byte |
| strap_err_o | output | 1 | Sticky flag for an unrecognised strap pattern |

## Verification
Every input passes through two synchronizer flops and one edge register. The decoded address therefore updates about four system cycles after the first SCL fall following a START. The match pulse and `rw_o` arrive about four cycles after the eighth SCL rise, and the pull-down changes about four cycles after the relevant SCL fall. The bench holds each bus quarter-period for eight system cycles. It samples on falling clock edges only after a full quarter-period has passed since the bus event, so each result is checked once it has settled and before the next bus edge could change it. Match pulses are counted by a monitor over the whole byte rather than looked for on one cycle, and the acknowledge is read on the wired SDA level both just before and during the ninth SCL high.

// File: rtl/i2c_strap_pkg.sv
// Package: shared types and helpers for the strap-addressed I2C target.
// Assumes the address base has its two low bits clear, so that the
// strap kind can be added to it without carry.
package i2c_strap_pkg;

    typedef enum logic [1:0] {
        TIE_GND = 2'd0,
        TIE_VCC = 2'd1,
        TIE_SDA = 2'd2,
        TIE_SCL = 2'd3
    } tie_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_ACK_WAIT,
        PH_ACK
    } phase_t;

    // Map a three-sample strap pattern {idle, start, first fall} to a tie kind.
    // Returns 1 when the pattern is one of the four legal ones.
    function automatic logic classify_strap(input logic [2:0] pat,
                                            output tie_kind_t kind);
        kind = TIE_GND;
        case (pat)
            3'b000:  begin kind = TIE_GND; return 1'b1; end
            3'b111:  begin kind = TIE_VCC; return 1'b1; end
            3'b100:  begin kind = TIE_SDA; return 1'b1; end
            3'b110:  begin kind = TIE_SCL; return 1'b1; end
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-bit two-or-more stage synchronizer for asynchronous bus lines.
// Assumes each bit is an independent slow level; resets to all ones so an
// idle (pulled-up) bus is seen during and just after reset.
module i2c_line_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '1;
                    else        pipe[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '1;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
// Module: detects START, STOP and SCL edges from synchronized bus lines.
// Assumes inputs are already synchronized; each event is a one-cycle pulse
// in the cycle the synchronized line shows the new level.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_q;
    logic sda_q;

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // SDA edges while SCL stays high are bus conditions; SCL edges are clocks.
    always_comb begin
        start_o = scl_q && scl_s && sda_q && !sda_s;
        stop_o  = scl_q && scl_s && !sda_q && sda_s;
        rise_o  = !scl_q && scl_s;
        fall_o  = scl_q && !scl_s;
    end

endmodule

// File: rtl/i2c_strap_decode.sv
// Module: decodes the target address from the strap pin behaviour around
// each START. Samples the strap while the bus idles, at START, and at the
// first SCL fall after START, then maps the pattern to one of four addresses.
// Assumes synchronized inputs sharing one latency so the tie follows exactly.
module i2c_strap_decode
    import i2c_strap_pkg::*;
#(
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              strap_s,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              fall_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              err_o
);

    logic      idle_smp;
    logic      start_smp;
    logic      armed;
    logic      pat_ok;
    tie_kind_t kind;

    // Track the strap level while the bus is idle (both lines high).
    always_ff @(posedge clk) begin
        if (!rst_n)                          idle_smp <= 1'b0;
        else if (scl_s && sda_s && !start_i) idle_smp <= strap_s;
    end

    // Capture the strap at START and arm the decode for the first SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_smp <= 1'b0;
            armed     <= 1'b0;
        end else if (start_i) begin
            start_smp <= strap_s;
            armed     <= 1'b1;
        end else if (stop_i || fall_i) begin
            armed     <= 1'b0;
        end
    end

    // Classify the three-sample pattern available at the first SCL fall.
    always_comb begin
        pat_ok = classify_strap({idle_smp, start_smp, strap_s}, kind);
    end

    // Update the address on a legal pattern; flag an illegal one (sticky).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= BASE_ADDR;
            err_o  <= 1'b0;
        end else if (armed && fall_i) begin
            if (pat_ok) addr_o <= BASE_ADDR + ADDR_W'(kind);
            else        err_o  <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_addr_engine.sv
// Module: shifts in the address byte, compares it with the decoded address
// and drives the acknowledge. STOP and START abort at any time.
// Assumes one-cycle event pulses from i2c_bus_events.
module i2c_addr_engine
    import i2c_strap_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              pull_o,
    output logic              match_o,
    output logic              rw_o
);

    localparam int CNT_W = $clog2(ADDR_W + 1);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] shreg;
    logic              hit;

    // Compare the seven received bits with the decoded address.
    always_comb begin
        hit = (shreg == addr_i);
    end

    // Phase sequencing: shift, compare at the R/W bit, acknowledge, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            pull_o  <= 1'b0;
            match_o <= 1'b0;
            rw_o    <= 1'b0;
        end else begin
            match_o <= 1'b0;
            if (start_i) begin
                phase  <= PH_SHIFT;
                cnt    <= '0;
                pull_o <= 1'b0;
            end else if (stop_i) begin
                phase  <= PH_IDLE;
                pull_o <= 1'b0;
            end else begin
                case (phase)
                    PH_SHIFT: if (rise_i) begin
                        if (cnt == CNT_W'(ADDR_W)) begin
                            rw_o    <= sda_s;
                            match_o <= hit;
                            phase   <= hit ? PH_ACK_WAIT : PH_IDLE;
                        end else begin
                            shreg <= {shreg[ADDR_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    PH_ACK_WAIT: if (fall_i) begin
                        pull_o <= 1'b1;
                        phase  <= PH_ACK;
                    end
                    PH_ACK: if (fall_i) begin
                        pull_o <= 1'b0;
                        phase  <= PH_IDLE;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_strap_target.sv
// Module: top of the strap-addressed I2C target address front end.
// Synchronizes the lines, finds bus events, decodes the strap address and
// runs the address phase. Assumes clk is many times faster than SCL.
module i2c_strap_target #(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 7'h48,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              match_o,
    output logic              rw_o,
    output logic              strap_err_o
);

    localparam int LINES = 3;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic             scl_s;
    logic             sda_s;
    logic             strap_s;
    logic             start_evt;
    logic             stop_evt;
    logic             rise_evt;
    logic             fall_evt;

    assign raw_lines = {strap_i, sda_i, scl_i};
    assign scl_s     = sync_lines[0];
    assign sda_s     = sync_lines[1];
    assign strap_s   = sync_lines[2];

    i2c_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (sync_lines)
    );

    i2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (start_evt),
        .stop_o  (stop_evt),
        .rise_o  (rise_evt),
        .fall_o  (fall_evt)
    );

    i2c_strap_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .strap_s (strap_s),
        .start_i (start_evt),
        .stop_i  (stop_evt),
        .fall_i  (fall_evt),
        .addr_o  (addr_o),
        .err_o   (strap_err_o)
    );

    i2c_addr_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_s   (sda_s),
        .start_i (start_evt),
        .stop_i  (stop_evt),
        .rise_i  (rise_evt),
        .fall_i  (fall_evt),
        .addr_i  (addr_o),
        .pull_o  (sda_pull_o),
        .match_o (match_o),
        .rw_o    (rw_o)
    );

endmodule

// File: rtl/i2c_strap_target_chk.sv
// Module: assertion checker for i2c_strap_target, attached by bind.
// Assumes it sees the top's ports and its internal bus-event pulses.
module i2c_strap_target_chk #(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              match_o,
    input logic              strap_err_o,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              fall_evt
);

    logic hit_seen;

    // Remember whether a match occurred since the last bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hit_seen <= 1'b0;
        else if (start_evt || stop_evt) hit_seen <= 1'b0;
        else if (match_o)               hit_seen <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (addr_o == BASE_ADDR && !sda_pull_o && !match_o && !strap_err_o));

    p_addr_family_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strap_err_o |=> strap_err_o);

    p_err_keeps_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_err_o) |-> $stable(addr_o));

    p_match_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    p_ack_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(fall_evt));

    p_ack_off_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> ($past(fall_evt) || $past(stop_evt) || $past(start_evt)));

    p_ack_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> hit_seen);

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o);

endmodule

bind i2c_strap_target i2c_strap_target_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_pull_o  (sda_pull_o),
    .addr_o      (addr_o),
    .match_o     (match_o),
    .strap_err_o (strap_err_o),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .fall_evt    (fall_evt)
);

// File: tb/tb_i2c_strap_target.sv
// Bench: drives a modelled bus master and strap wiring, checks the
// address decode, the match pulse, R/W and the acknowledge at the wired SDA.
module tb_i2c_strap_target;

    localparam int Q = 8;  // system cycles per bus quarter-period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    int         mode = 0;      // 0 gnd, 1 vcc, 2 sda, 3 scl, 4 illegal (inverted sda)
    logic       strap;
    logic       sda_line;
    logic       sda_pull;
    logic [6:0] addr;
    logic       match;
    logic       rw;
    logic       strap_err;

    int checks = 0;
    int errors = 0;
    int match_cnt = 0;
    int pull_cnt = 0;
    logic [6:0] exp_addr = 7'h48;
    logic       exp_err = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    always_comb begin
        case (mode)
            0:       strap = 1'b0;
            1:       strap = 1'b1;
            2:       strap = sda_line;
            3:       strap = scl_m;
            default: strap = ~sda_line;
        endcase
    end

    i2c_strap_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .sda_pull_o  (sda_pull),
        .addr_o      (addr),
        .match_o     (match),
        .rw_o        (rw),
        .strap_err_o (strap_err)
    );

    // Count match pulses and pull-down cycles for window checks.
    always @(posedge clk) begin
        if (match)    match_cnt <= match_cnt + 1;
        if (sda_pull) pull_cnt  <= pull_cnt + 1;
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected address for a strap mode, following R2..R6.
    function automatic logic [6:0] model_addr(input int m, input logic [6:0] prev);
        if (m >= 0 && m <= 3) return 7'h48 + 7'(m);
        return prev;
    endfunction

    function automatic string mode_req(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic bus_start();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rep_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        bus_start();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
        chk(sda_pull == 1'b0, "R10 pull after stop", sda_pull, 0);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // Send eight bits plus the acknowledge slot; check match, R/W and ACK.
    task automatic send_byte(input logic [7:0] b, input bit exp_hit, input bit live, input string req);
        int m0 = match_cnt;
        int p0 = pull_cnt;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        chk((match_cnt - m0) == int'(exp_hit), {req, " R7 match pulses"}, match_cnt - m0, int'(exp_hit));
        if (live) chk(rw == b[0], "R7 rw bit", rw, b[0]);
        sda_m = 1'b1; tick(Q);
        chk(sda_line == !exp_hit, {req, " R8 ack before rise"}, sda_line, !exp_hit);
        scl_m = 1'b1; tick(Q);
        chk(sda_line == !exp_hit, {req, " R8 ack during high"}, sda_line, !exp_hit);
        tick(Q);
        scl_m = 1'b0; tick(Q);
        chk(sda_pull == 1'b0, "R8 release after ack", sda_pull, 0);
        if (!exp_hit) chk(pull_cnt == p0, {req, " R9 no pull on mismatch"}, pull_cnt - p0, 0);
    endtask

    task automatic xfer(input int m, input logic [6:0] a7, input logic rwb);
        logic hit;
        mode = m;
        tick(2 * Q);
        bus_start();
        exp_addr = model_addr(m, exp_addr);
        if (m > 3) exp_err = 1'b1;
        chk(addr == exp_addr, {mode_req(m), " decoded address"}, addr, exp_addr);
        chk(strap_err == exp_err, "R6 strap error flag", strap_err, exp_err);
        hit = (a7 == exp_addr);
        send_byte({a7, rwb}, hit, 1'b1, mode_req(m));
        bus_stop();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk(addr == 7'h48, "R1 reset addr", addr, 7'h48);
        chk(sda_pull == 1'b0 && match == 1'b0, "R1 reset pull/match", {sda_pull, match}, 0);
        chk(strap_err == 1'b0, "R1 reset error", strap_err, 0);

        // Directed: each tie with a matching address and both R/W values.
        xfer(0, 7'h48, 1'b0);
        xfer(1, 7'h49, 1'b1);
        xfer(2, 7'h4A, 1'b0);
        xfer(3, 7'h4B, 1'b1);
        // Mismatch: neighbour address of another tie (R9).
        xfer(0, 7'h49, 1'b1);
        xfer(3, 7'h48, 1'b0);

        // Illegal pattern keeps last address and sets sticky error (R6).
        xfer(4, 7'h4B, 1'b0);
        xfer(1, 7'h49, 1'b0);
        chk(strap_err == 1'b1, "R6 error stays set", strap_err, 1);

        // STOP mid-byte, then a matching byte without START (R10).
        mode = 0; tick(2 * Q);
        bus_start();
        exp_addr = 7'h48;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        scl_m = 1'b0; tick(Q);
        send_byte({7'h48, 1'b0}, 1'b0, 1'b0, "R10 no start");
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);

        // Repeated START mid-byte with a new tie re-decodes (R11).
        mode = 0; tick(2 * Q);
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        mode = 1;
        bus_rep_start();
        exp_addr = 7'h49;
        chk(addr == 7'h49, "R11 re-decoded address", addr, 7'h49);
        send_byte({7'h49, 1'b1}, 1'b1, 1'b1, "R11");
        bus_stop();

        // Constrained random: legal ties, half the bytes aimed at the target.
        for (int n = 0; n < 24; n++) begin
            int m = int'($urandom % 4);
            logic [6:0] a = (($urandom % 2) == 0) ? (7'h48 + 7'(m)) : 7'($urandom);
            xfer(m, a, 1'($urandom));
        end

        finish_run();
    end

endmodule